// File: doc/BRIEF.md
# Thread Low-Power State Controller

This block follows the power state of one hardware thread. The thread starts out active. Instruction-side requests can send it into a light halt, into a monitor-wait, or into one of two deeper sleep levels. Requests arrive as single-cycle pulses: a halt, a monitor-wait carrying a depth hint, and level-register reads for depth 2, 4 or 6. The thread returns to the active state when a wake source fires. These sources are a set of interrupt-class break pins and a monitor event.

An active-low stop-clock pin sends the thread into a stop-grant state. This happens only from the active state or from either light state. On release, the thread goes back to exactly the state it left. In the deep states the pin has no effect, and there it also blocks wake-up. A depth-6 level read is held pending until a cache-flushed flag reports the cache empty.

Pin inputs first pass through a reset-initialised synchronizer. The controller reports its state as a one-hot vector and raises a one-cycle wake pulse each time it returns to the active state.

Top module: `thread_cstate_ctrl`

## Requirements
- R1: After reset, `state_oh` is 6'b000001 (active) and `wake_pulse` is 0. The one-hot bit positions are: 0 active, 1 halt-sleep, 2 monitor-wait, 3 level-2 sleep, 4 deep sleep (levels 4 and 6), 5 stop-grant. Exactly one bit is set at all times.
- R2: A `halt_req` pulse in the active state enters halt-sleep on the next edge. Halt-sleep returns to active only on a halt break, meaning any synchronized break source firing. A monitor event alone does not wake it.
- R3: A `mwait_req` pulse with `mwait_hint` = 0 enters monitor-wait. Monitor-wait returns to active on a core break. A core break is a halt break or a synchronized monitor event, taken only while the stop-clock pin is deasserted (high).
- R4: Level-2 sleep is entered by `lvl2_rd` or by a monitor-wait with hint 1. Deep sleep is entered by `lvl4_rd` or by a monitor-wait with hint 2 or 3. Both states return to active on a core break.
- R5: A `lvl6_rd` pulse enters deep sleep only once `cache_flushed` (on-chip, not synchronized) is 1. Until then the thread stays active and the request stays pending. The pending request is dropped when the thread leaves the active state by any other path.
- R6: When several entry requests arrive in the same cycle, the deepest one wins. From shallowest to deepest the order is: halt-sleep, monitor-wait, level-2 sleep, deep sleep.
- R7: Every bit of `brk_pins` is a halt-break source. Bits selected by `EDGE_MASK` (default: bit 0, the address-mask line) count only in a cycle where their synchronized value changed. A steady level on such a bit does not break.
- R8: Stop-clock asserted (low) in active, halt-sleep or monitor-wait enters stop-grant. Stop-grant is held while the pin stays asserted. Deassertion returns the thread to the state it was in before stop-grant. Stop-clock takes priority over same-cycle requests and breaks.
- R9: Stop-clock assertion and deassertion have no effect in level-2 and deep sleep. While the pin is asserted, breaks do not wake those states.
- R10: Break, monitor and stop-clock pins pass through a 2-flop synchronizer. A pin change driven between edges takes effect on `state_oh` at the third rising edge that follows.
- R11: `wake_pulse` is high for exactly one cycle, aligned with the first cycle of each return to active from any state. It is never high otherwise.
- R12: Entry requests are ignored in every state other than active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| halt_req | input | 1 | Halt instruction pulse |
| mwait_req | input | 1 | Monitor-wait pulse |
| mwait_hint | input | 2 | Monitor-wait depth: 0 light, 1 level 2, 2/3 deep |
| lvl2_rd | input | 1 | Level-2 register read pulse |
| lvl4_rd | input | 1 | Level-4 register read pulse |
| lvl6_rd | input | 1 | Level-6 register read pulse |
| cache_flushed | input | 1 | Cache reduced to zero ways |
| brk_pins | input | NUM_BRK | Asynchronous break source pins |
| mon_evt | input | 1 | Asynchronous monitor event |
| stop_clk_n | input | 1 | Asynchronous stop-clock pin, active low |
| state_oh | output | 6 | One-hot current state |
| wake_pulse | output | 1 | One-cycle pulse on return to active |

## Verification
The bench targets the stop-clock pin held asserted across the deep states. A design that honours it there would fall into stop-grant, or wake on a break it should ignore. The bench also checks that stop-grant returns to the light state it left; a controller that always exits to active would lose a sleeping thread. It checks the pending level-6 read both before the flush, where an eager design enters deep sleep too early, and after an intervening halt, where a sticky design would wake into deep sleep unbidden. Finally, it checks a steady address-mask level, which a level-sensitive decoder would treat as an endless break, and same-cycle request mixes, where a wrong priority picks a shallower state.

// File: rtl/cstate_pkg.sv
package cstate_pkg;

    localparam int NUM_ST = 6;

    typedef enum logic [2:0] {
        ST_ACT  = 3'd0,
        ST_HALT = 3'd1,
        ST_MON  = 3'd2,
        ST_LV2  = 3'd3,
        ST_DEEP = 3'd4,
        ST_SG   = 3'd5
    } cst_e;

    typedef struct packed {
        cst_e cur;
        cst_e saved;
        logic l6_pend;
        logic wake;
    } fsm_regs_t;

    function automatic logic [NUM_ST-1:0] to_onehot(cst_e s);
        logic [NUM_ST-1:0] oh;
        oh = '0;
        oh[s] = 1'b1;
        return oh;
    endfunction

endpackage

// File: rtl/cstate_sync.sv
module cstate_sync #(
    parameter int             W       = 1,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stg_d [STAGES];
    logic [W-1:0] stg_q [STAGES];

    always_comb begin
        stg_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
        end else begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= stg_d[i];
        end
    end

    assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/cstate_brk_comb.sv
module cstate_brk_comb #(
    parameter int                 NUM_BRK   = 8,
    parameter logic [NUM_BRK-1:0] EDGE_MASK = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_BRK-1:0] brk_s,
    input  logic               mon_s,
    input  logic               stp_n_s,
    output logic               halt_brk,
    output logic               core_brk,
    output logic               stp_on
);
    logic [NUM_BRK-1:0] hit;

    for (genvar g = 0; g < NUM_BRK; g++) begin : g_src
        if (EDGE_MASK[g]) begin : g_edge
            logic prev_d, prev_q;
            always_comb prev_d = brk_s[g];
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) prev_q <= 1'b0;
                else        prev_q <= prev_d;
            end
            assign hit[g] = brk_s[g] ^ prev_q;
        end else begin : g_level
            assign hit[g] = brk_s[g];
        end
    end

    assign halt_brk = |hit;
    assign stp_on   = ~stp_n_s;
    assign core_brk = (halt_brk | mon_s) & ~stp_on;

    // R9
    core_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_brk |-> stp_n_s);
endmodule

// File: rtl/cstate_fsm.sv
module cstate_fsm
    import cstate_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              halt_req,
    input  logic              mwait_req,
    input  logic [1:0]        mwait_hint,
    input  logic              lvl2_rd,
    input  logic              lvl4_rd,
    input  logic              lvl6_rd,
    input  logic              cache_flushed,
    input  logic              halt_brk,
    input  logic              core_brk,
    input  logic              stp_on,
    output logic [NUM_ST-1:0] state_oh,
    output logic              wake
);
    fsm_regs_t r_d, r_q;
    logic      l6_want;

    always_comb begin
        r_d      = r_q;
        r_d.wake = 1'b0;
        l6_want  = lvl6_rd | r_q.l6_pend;
        unique case (r_q.cur)
            ST_ACT: begin
                if (stp_on) begin
                    r_d.cur   = ST_SG;
                    r_d.saved = ST_ACT;
                end else if (lvl4_rd || (mwait_req && mwait_hint[1])
                             || (l6_want && cache_flushed)) begin
                    r_d.cur = ST_DEEP;
                end else if (lvl2_rd || (mwait_req && mwait_hint == 2'd1)) begin
                    r_d.cur = ST_LV2;
                end else if (mwait_req) begin
                    r_d.cur = ST_MON;
                end else if (halt_req) begin
                    r_d.cur = ST_HALT;
                end
            end
            ST_HALT: begin
                if (stp_on) begin
                    r_d.cur   = ST_SG;
                    r_d.saved = ST_HALT;
                end else if (halt_brk) begin
                    r_d.cur = ST_ACT;
                end
            end
            ST_MON: begin
                if (stp_on) begin
                    r_d.cur   = ST_SG;
                    r_d.saved = ST_MON;
                end else if (core_brk) begin
                    r_d.cur = ST_ACT;
                end
            end
            ST_LV2, ST_DEEP: begin
                if (core_brk) r_d.cur = ST_ACT;
            end
            ST_SG: begin
                if (!stp_on) r_d.cur = r_q.saved;
            end
            default: r_d.cur = ST_ACT;
        endcase
        r_d.l6_pend = (r_d.cur == ST_ACT) && (r_q.cur == ST_ACT) && l6_want;
        r_d.wake    = (r_d.cur == ST_ACT) && (r_q.cur != ST_ACT);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{cur: ST_ACT, saved: ST_ACT, l6_pend: 1'b0, wake: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign state_oh = to_onehot(r_q.cur);
    assign wake     = r_q.wake;

    // R1
    onehot_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(state_oh) == 1);
    // R11
    wake_on_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake |-> (state_oh[0] && $past(r_q.cur) != ST_ACT));
    // R9
    deep_no_sg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.cur == ST_LV2 || r_q.cur == ST_DEEP) |=> r_q.cur != ST_SG);
    // R8
    sg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.cur == ST_SG && stp_on) |=> r_q.cur == ST_SG);
    // R12
    halt_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.cur == ST_HALT && !stp_on && !halt_brk) |=> $stable(state_oh));
endmodule

// File: rtl/thread_cstate_ctrl.sv
module thread_cstate_ctrl #(
    parameter int                 NUM_BRK     = 8,
    parameter logic [NUM_BRK-1:0] EDGE_MASK   = NUM_BRK'(1),
    parameter int                 SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               halt_req,
    input  logic               mwait_req,
    input  logic [1:0]         mwait_hint,
    input  logic               lvl2_rd,
    input  logic               lvl4_rd,
    input  logic               lvl6_rd,
    input  logic               cache_flushed,
    input  logic [NUM_BRK-1:0] brk_pins,
    input  logic               mon_evt,
    input  logic               stop_clk_n,
    output logic [5:0]         state_oh,
    output logic               wake_pulse
);
    localparam int PIN_W = NUM_BRK + 2;
    localparam logic [PIN_W-1:0] PIN_RST = {1'b1, 1'b0, {NUM_BRK{1'b0}}};

    logic [PIN_W-1:0] pins_s;
    logic             halt_brk, core_brk, stp_on;

    cstate_sync #(.W(PIN_W), .STAGES(SYNC_STAGES), .RST_VAL(PIN_RST)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({stop_clk_n, mon_evt, brk_pins}),
        .dout (pins_s)
    );

    cstate_brk_comb #(.NUM_BRK(NUM_BRK), .EDGE_MASK(EDGE_MASK)) u_brk (
        .clk     (clk),
        .rst_n   (rst_n),
        .brk_s   (pins_s[NUM_BRK-1:0]),
        .mon_s   (pins_s[NUM_BRK]),
        .stp_n_s (pins_s[NUM_BRK+1]),
        .halt_brk(halt_brk),
        .core_brk(core_brk),
        .stp_on  (stp_on)
    );

    cstate_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .halt_req     (halt_req),
        .mwait_req    (mwait_req),
        .mwait_hint   (mwait_hint),
        .lvl2_rd      (lvl2_rd),
        .lvl4_rd      (lvl4_rd),
        .lvl6_rd      (lvl6_rd),
        .cache_flushed(cache_flushed),
        .halt_brk     (halt_brk),
        .core_brk     (core_brk),
        .stp_on       (stp_on),
        .state_oh     (state_oh),
        .wake         (wake_pulse)
    );
endmodule

// File: tb/tb_thread_cstate_ctrl.sv
module tb_thread_cstate_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int NB = 8;

    logic clk = 1'b0, rst_n = 1'b0;
    logic halt_req = 0, mwait_req = 0, lvl2_rd = 0, lvl4_rd = 0, lvl6_rd = 0;
    logic [1:0] mwait_hint = 0;
    logic cache_flushed = 0, mon_evt = 0, stop_clk_n = 1;
    logic [NB-1:0] brk_pins = '0;
    logic [5:0] state_oh;
    logic wake_pulse;

    int checks = 0, failures = 0, cycles = 0;
    string cur_req = "R1";

    // behavioural reference: 0 act,1 halt,2 mon,3 lv2,4 deep,5 sg
    int m_st, m_saved;
    bit m_pend, m_wake;
    bit [NB-1:0] b_hist [$];
    bit mon_hist [$];
    bit stp_hist [$];
    bit a20_prev;

    thread_cstate_ctrl #(.NUM_BRK(NB)) dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st = 0; m_saved = 0; m_pend = 0; m_wake = 0; a20_prev = 0;
            b_hist = {NB'(0), NB'(0)};
            mon_hist = {1'b0, 1'b0};
            stp_hist = {1'b1, 1'b1};
        end else begin
            bit [NB-1:0] b; bit mon, stp, hb, cb; int nxt, want;
            b = b_hist[1]; mon = mon_hist[1]; stp = !stp_hist[1];
            hb = (b[NB-1:1] != 0) || (b[0] != a20_prev);
            cb = (hb || mon) && !stp;
            nxt = m_st;
            case (m_st)
                0: if (stp) begin nxt = 5; m_saved = 0; end
                   else begin
                       want = 0;
                       if (halt_req) want = 1;
                       if (mwait_req && mwait_hint == 0) want = 2;
                       if (lvl2_rd || (mwait_req && mwait_hint == 1)) want = 3;
                       if (lvl4_rd || (mwait_req && mwait_hint >= 2) ||
                           ((lvl6_rd || m_pend) && cache_flushed)) want = 4;
                       nxt = want;
                   end
                1: if (stp) begin nxt = 5; m_saved = 1; end else if (hb) nxt = 0;
                2: if (stp) begin nxt = 5; m_saved = 2; end else if (cb) nxt = 0;
                3, 4: if (cb) nxt = 0;
                default: if (!stp) nxt = m_saved;
            endcase
            m_pend = (m_st == 0 && nxt == 0) ? (lvl6_rd || m_pend) : 1'b0;
            m_wake = (nxt == 0 && m_st != 0);
            m_st = nxt;
            a20_prev = b[0];
            b_hist.pop_back(); b_hist.push_front(brk_pins);
            mon_hist.pop_back(); mon_hist.push_front(mon_evt);
            stp_hist.pop_back(); stp_hist.push_front(stop_clk_n);
        end
    end

    // per-cycle comparison against the reference
    always @(negedge clk) begin
        if (rst_n) begin
            checks++;
            if (state_oh != (6'(1) << m_st) || wake_pulse != m_wake) begin
                failures++;
                $display("FAIL %s model: state_oh=%b wake=%b expected %b wake=%b",
                         cur_req, state_oh, wake_pulse, 6'(1) << m_st, m_wake);
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            failures++;
            $display("FAIL watchdog: cycles=%0d expected <=20000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_st(logic [5:0] exp, logic expw, string req);
        checks++;
        if (state_oh !== exp || wake_pulse !== expw) begin
            failures++;
            $display("FAIL %s: state_oh=%b wake=%b expected %b wake=%b",
                     req, state_oh, wake_pulse, exp, expw);
        end
    endtask

    task automatic req(bit h, bit mw, logic [1:0] hint, bit l2, bit l4, bit l6);
        halt_req = h; mwait_req = mw; mwait_hint = hint;
        lvl2_rd = l2; lvl4_rd = l4; lvl6_rd = l6;
        tick(1);
        halt_req = 0; mwait_req = 0; mwait_hint = 0;
        lvl2_rd = 0; lvl4_rd = 0; lvl6_rd = 0;
    endtask

    task automatic brk_pulse(int idx);
        brk_pins[idx] = 1'b1; tick(1); brk_pins[idx] = 1'b0; tick(2);
    endtask

    task automatic mon_pulse();
        mon_evt = 1'b1; tick(1); mon_evt = 1'b0; tick(2);
    endtask

    initial begin
        tick(2);
        rst_n = 1'b1;
        tick(1);
        cur_req = "R1";
        expect_st(6'b000001, 1'b0, "R1");

        cur_req = "R2";
        req(1, 0, 0, 0, 0, 0);
        expect_st(6'b000010, 1'b0, "R2");
        brk_pins[3] = 1'b1; tick(1); brk_pins[3] = 1'b0; tick(1);
        expect_st(6'b000010, 1'b0, "R10");
        tick(1);
        expect_st(6'b000001, 1'b1, "R2");
        tick(1);
        expect_st(6'b000001, 1'b0, "R11");

        cur_req = "R3";
        req(0, 1, 0, 0, 0, 0);
        expect_st(6'b000100, 1'b0, "R3");
        mon_pulse();
        expect_st(6'b000001, 1'b1, "R3");
        req(1, 0, 0, 0, 0, 0);
        mon_pulse(); tick(1);
        expect_st(6'b000010, 1'b0, "R2");
        brk_pulse(5);
        expect_st(6'b000001, 1'b1, "R2");

        cur_req = "R4";
        req(0, 0, 0, 1, 0, 0);
        expect_st(6'b001000, 1'b0, "R4");
        mon_pulse();
        expect_st(6'b000001, 1'b1, "R4");
        req(0, 0, 0, 0, 1, 0);
        expect_st(6'b010000, 1'b0, "R4");
        brk_pulse(2);
        expect_st(6'b000001, 1'b1, "R4");
        req(0, 1, 2, 0, 0, 0);
        expect_st(6'b010000, 1'b0, "R4");
        mon_pulse();
        req(0, 1, 1, 0, 0, 0);
        expect_st(6'b001000, 1'b0, "R4");

        cur_req = "R9";
        stop_clk_n = 1'b0; tick(5);
        expect_st(6'b001000, 1'b0, "R9");
        brk_pulse(4); mon_pulse(); tick(1);
        expect_st(6'b001000, 1'b0, "R9");
        cur_req = "R12";
        req(1, 0, 0, 0, 0, 0);
        expect_st(6'b001000, 1'b0, "R12");
        cur_req = "R9";
        stop_clk_n = 1'b1; tick(4);
        expect_st(6'b001000, 1'b0, "R9");
        brk_pulse(4);
        expect_st(6'b000001, 1'b1, "R9");

        cur_req = "R8";
        stop_clk_n = 1'b0; tick(3);
        expect_st(6'b100000, 1'b0, "R8");
        req(0, 0, 0, 0, 1, 0);
        expect_st(6'b100000, 1'b0, "R12");
        stop_clk_n = 1'b1; tick(3);
        expect_st(6'b000001, 1'b1, "R8");
        req(0, 1, 0, 0, 0, 0);
        stop_clk_n = 1'b0; tick(3);
        expect_st(6'b100000, 1'b0, "R8");
        stop_clk_n = 1'b1; tick(3);
        expect_st(6'b000100, 1'b0, "R8");
        mon_pulse();
        req(1, 0, 0, 0, 0, 0);
        stop_clk_n = 1'b0; tick(3);
        stop_clk_n = 1'b1; tick(3);
        expect_st(6'b000010, 1'b0, "R8");
        brk_pulse(1);
        expect_st(6'b000001, 1'b1, "R8");

        cur_req = "R5";
        req(0, 0, 0, 0, 0, 1);
        tick(3);
        expect_st(6'b000001, 1'b0, "R5");
        cache_flushed = 1'b1; tick(1);
        expect_st(6'b010000, 1'b0, "R5");
        cache_flushed = 1'b0;
        mon_pulse();
        req(0, 0, 0, 0, 0, 1);
        req(1, 0, 0, 0, 0, 0);
        expect_st(6'b000010, 1'b0, "R5");
        brk_pulse(6);
        cache_flushed = 1'b1; tick(2);
        expect_st(6'b000001, 1'b0, "R5");
        cache_flushed = 1'b0;

        cur_req = "R6";
        req(1, 1, 0, 1, 0, 0);
        expect_st(6'b001000, 1'b0, "R6");
        mon_pulse();
        req(1, 1, 0, 0, 0, 0);
        expect_st(6'b000100, 1'b0, "R6");
        mon_pulse();
        req(1, 1, 3, 1, 0, 0);
        expect_st(6'b010000, 1'b0, "R6");
        mon_pulse();

        cur_req = "R7";
        req(1, 0, 0, 0, 0, 0);
        brk_pins[0] = 1'b1; tick(3);
        expect_st(6'b000001, 1'b1, "R7");
        req(1, 0, 0, 0, 0, 0);
        tick(4);
        expect_st(6'b000010, 1'b0, "R7");
        brk_pins[0] = 1'b0; tick(3);
        expect_st(6'b000001, 1'b1, "R7");
        for (int i = 1; i < NB; i++) begin
            req(1, 0, 0, 0, 0, 0);
            brk_pulse(i);
            expect_st(6'b000001, 1'b1, "R7");
        end

        tick(3);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule